// File: doc/BRIEF.md
# Program Counter Sequencer with Branch Delay Slot

This block keeps the program-counter state of a 32-bit processor whose taken branches are followed by exactly one delay-slot instruction. It holds three addresses: the instruction being fetched now, the one fetched before it, and the one to fetch next. Each enabled step moves the addresses forward by one. When the executing instruction takes a branch, the target goes into the next-address register. The delay-slot instruction at the old sequential address therefore runs first, and control reaches the target on the step after that.

The sequencer also handles two kinds of fetch-time events. A breakpoint match halts the step the first time it is seen. On the retry, the match at the same address is ignored so that the instruction can run. An exception raised at fetch still advances the PC but executes nothing, and it loads its vector as the next address. A step enable gates every state change, so a pipeline stall freezes the whole sequencer.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is high and after its release with no step, `pc` and `pc_prev` read 0, `pc_next` reads 4, and `in_delay_slot`, `halt_o` and `exec_o` are all 0.
- R2: A step with no breakpoint halt, no exception and no branch executes. `pc_prev` takes the old `pc`, `pc` takes the old `pc_next`, `pc_next` becomes the new `pc` plus 4, and `exec_o` reads 1 after that step.
- R3: A taken branch on an executing step makes `pc` the delay-slot address (the old `pc_next`) and sets `in_delay_slot` to 1. It loads `br_target` into `pc_next`, so the step after that reaches the target.
- R4: `in_delay_slot` returns to 0 after any step on which no branch was taken.
- R5: A breakpoint match on a step whose previous step did not halt raises `halt_o` for one cycle. No instruction executes, and `pc`, `pc_prev`, `pc_next` and `in_delay_slot` keep their values.
- R6: On the first step after a halted step, `bp_match` is ignored and the step executes normally. This holds even if idle cycles lie between the two steps. A match on a later step halts again.
- R7: An exception step (`exc_valid` high, not halted) advances `pc_prev` and `pc` as in R2. It loads `exc_vector` into `pc_next`, clears `in_delay_slot`, leaves `exec_o` at 0 and ignores `br_taken`.
- R8: Priority on a step runs breakpoint halt first, then exception, then taken branch, then sequential advance.
- R9: While `step_en` is low, no PC register or the delay flag changes, whatever the other inputs do, and `halt_o` and `exec_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the sequencer this cycle |
| br_taken | input | 1 | The instruction executing this step takes a branch |
| br_target | input | 32 | Branch destination address |
| exc_valid | input | 1 | Exception raised at fetch this step |
| exc_vector | input | 32 | Exception handler address |
| bp_match | input | 1 | Fetch address matches a breakpoint |
| pc | output | 32 | Address of the current instruction |
| pc_prev | output | 32 | Address of the previous instruction |
| pc_next | output | 32 | Address to fetch on the next step |
| in_delay_slot | output | 1 | Current instruction sits in a branch delay slot |
| halt_o | output | 1 | Last step was stopped by a breakpoint |
| exec_o | output | 1 | Last step executed an instruction |

## Verification
The hardest state to reach is a breakpoint retry with the skip flag armed. It is harder still when that retry coincides with an exception, when it falls on a delay-slot instruction, or when stall cycles separate the halt from the retry. The stimulus first drives a taken branch so that the halted instruction is a delay slot. It then holds `bp_match` high across the halt, several idle cycles and the retry, and combines the halt with `exc_valid` so that the exception only takes effect on the retry. A behavioural model advanced from the same inputs is compared with every output on every clock.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  // Kind of step decided at fetch time
  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_HALT = 2'd1,
    STEP_TRAP = 2'd2,
    STEP_RUN  = 2'd3
  } step_kind_e;
endpackage

// File: rtl/pcs_fetch_gate.sv
module pcs_fetch_gate
  import pcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       step_en,
  input  logic       bp_match,
  input  logic       exc_valid,
  output step_kind_e kind
);
  // Set after a halting step so that the retry passes the breakpoint
  logic skip_q;

  always_comb begin
    if (!step_en)                kind = STEP_IDLE;
    else if (bp_match && !skip_q) kind = STEP_HALT;
    else if (exc_valid)          kind = STEP_TRAP;
    else                         kind = STEP_RUN;
  end

  always_ff @(posedge clk) begin
    if (rst)          skip_q <= 1'b0;
    else if (step_en) skip_q <= (kind == STEP_HALT);
  end
endmodule

// File: rtl/pcs_next_calc.sv
module pcs_next_calc
  import pcs_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  step_kind_e       kind,
  input  logic [XLEN-1:0]  cur_next,
  input  logic             br_taken,
  input  logic [XLEN-1:0]  br_target,
  input  logic [XLEN-1:0]  exc_vector,
  output logic [XLEN-1:0]  nxt_pc,
  output logic [XLEN-1:0]  nxt_next,
  output logic             nxt_dly
);
  localparam logic [XLEN-1:0] INCR = XLEN'(INSN_BYTES);

  always_comb begin
    nxt_pc = cur_next;
    if (kind == STEP_TRAP) begin
      nxt_next = exc_vector;
      nxt_dly  = 1'b0;
    end else if (br_taken) begin
      nxt_next = br_target;
      nxt_dly  = 1'b1;
    end else begin
      nxt_next = cur_next + INCR;
      nxt_dly  = 1'b0;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            br_taken,
  input  logic [XLEN-1:0] br_target,
  input  logic            exc_valid,
  input  logic [XLEN-1:0] exc_vector,
  input  logic            bp_match,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_prev,
  output logic [XLEN-1:0] pc_next,
  output logic            in_delay_slot,
  output logic            halt_o,
  output logic            exec_o
);
  localparam logic [XLEN-1:0] RESET_NEXT = RESET_PC + XLEN'(INSN_BYTES);

  step_kind_e      kind;
  logic [XLEN-1:0] nxt_pc, nxt_next;
  logic            nxt_dly;
  logic            advance;

  pcs_fetch_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .step_en  (step_en),
    .bp_match (bp_match),
    .exc_valid(exc_valid),
    .kind     (kind)
  );

  pcs_next_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_calc (
    .kind      (kind),
    .cur_next  (pc_next),
    .br_taken  (br_taken),
    .br_target (br_target),
    .exc_vector(exc_vector),
    .nxt_pc    (nxt_pc),
    .nxt_next  (nxt_next),
    .nxt_dly   (nxt_dly)
  );

  assign advance = (kind == STEP_RUN) || (kind == STEP_TRAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc            <= RESET_PC;
      pc_prev       <= RESET_PC;
      pc_next       <= RESET_NEXT;
      in_delay_slot <= 1'b0;
      halt_o        <= 1'b0;
      exec_o        <= 1'b0;
    end else begin
      halt_o <= (kind == STEP_HALT);
      exec_o <= (kind == STEP_RUN);
      if (advance) begin
        pc_prev       <= pc;
        pc            <= nxt_pc;
        pc_next       <= nxt_next;
        in_delay_slot <= nxt_dly;
      end
    end
  end
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            step_en,
  input logic [XLEN-1:0] br_target,
  input logic            exc_valid,
  input logic [XLEN-1:0] exc_vector,
  input logic            bp_match,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] pc_prev,
  input logic [XLEN-1:0] pc_next,
  input logic            in_delay_slot,
  input logic            halt_o,
  input logic            exec_o
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(pc) && $stable(pc_prev) && $stable(pc_next)
                  && $stable(in_delay_slot) && !halt_o && !exec_o));

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    exec_o |-> (pc == $past(pc_next) && pc_prev == $past(pc)));

  // R3
  slot_target_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_o && in_delay_slot) |-> (pc_next == $past(br_target)));

  // R5
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    halt_o |-> ($stable(pc) && $stable(pc_next) && $stable(in_delay_slot) && !exec_o));

  // R6
  single_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_o && step_en) |=> !halt_o);

  // R7
  trap_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !bp_match && exc_valid) |=>
      (pc_next == $past(exc_vector) && !in_delay_slot && !exec_o));
endmodule

bind pc_sequencer pcs_checker #(.XLEN(XLEN)) u_pcs_checker (
  .clk          (clk),
  .rst          (rst),
  .step_en      (step_en),
  .br_target    (br_target),
  .exc_valid    (exc_valid),
  .exc_vector   (exc_vector),
  .bp_match     (bp_match),
  .pc           (pc),
  .pc_prev      (pc_prev),
  .pc_next      (pc_next),
  .in_delay_slot(in_delay_slot),
  .halt_o       (halt_o),
  .exec_o       (exec_o)
);

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_en = 1'b0, br_taken = 1'b0, exc_valid = 1'b0, bp_match = 1'b0;
  logic [31:0] br_target = '0, exc_vector = '0;
  logic [31:0] pc, pc_prev, pc_next;
  logic        in_delay_slot, halt_o, exec_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_pc, m_prev, m_next;
  logic        m_dly, m_skip, m_halt, m_exec;

  always #5 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rst(rst), .step_en(step_en), .br_taken(br_taken),
    .br_target(br_target), .exc_valid(exc_valid), .exc_vector(exc_vector),
    .bp_match(bp_match), .pc(pc), .pc_prev(pc_prev), .pc_next(pc_next),
    .in_delay_slot(in_delay_slot), .halt_o(halt_o), .exec_o(exec_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk(req, "pc", pc, m_pc);
    chk(req, "pc_prev", pc_prev, m_prev);
    chk(req, "pc_next", pc_next, m_next);
    chk(req, "in_delay_slot", 32'(in_delay_slot), 32'(m_dly));
    chk(req, "halt_o", 32'(halt_o), 32'(m_halt));
    chk(req, "exec_o", 32'(exec_o), 32'(m_exec));
  endtask

  // Apply one cycle of inputs, advance the model, compare at the negedge
  task automatic cyc(input logic s, input logic b, input logic [31:0] t,
                     input logic e, input logic [31:0] v, input logic p,
                     input string req);
    step_en = s; br_taken = b; br_target = t;
    exc_valid = e; exc_vector = v; bp_match = p;
    if (rst) begin
      m_pc = 0; m_prev = 0; m_next = 4; m_dly = 0; m_skip = 0;
      m_halt = 0; m_exec = 0;
    end else if (!s) begin
      m_halt = 0; m_exec = 0;
    end else if (p && !m_skip) begin
      m_halt = 1; m_exec = 0; m_skip = 1;
    end else begin
      m_skip = 0; m_halt = 0;
      m_prev = m_pc; m_pc = m_next;
      if (e) begin
        m_next = v; m_dly = 0; m_exec = 0;
      end else begin
        m_dly = b; m_next = b ? t : m_pc + 4; m_exec = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state while in reset and right after release
    repeat (3) cyc(1, 1, 32'h40, 1, 32'h80, 1, "R1");
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, "R1");
    chk("R1", "pc after reset", pc, 32'h0);
    chk("R1", "pc_next after reset", pc_next, 32'h4);

    // R2: sequential stepping
    repeat (4) cyc(1, 0, 32'hdead, 0, 0, 0, "R2");
    chk("R2", "pc after 4 steps", pc, 32'h10);

    // R9: stalled with every other input active
    repeat (3) cyc(0, 1, 32'h500, 1, 32'h600, 1, "R9");
    chk("R9", "pc held while stalled", pc, 32'h10);

    // R3/R4: branch, delay slot, then target
    cyc(1, 1, 32'h100, 0, 0, 0, "R3");
    chk("R3", "slot pc", pc, 32'h14);
    chk("R3", "in_delay_slot", 32'(in_delay_slot), 32'd1);
    chk("R3", "pc_next target", pc_next, 32'h100);
    cyc(1, 0, 0, 0, 0, 0, "R4");
    chk("R4", "pc at target", pc, 32'h100);
    chk("R4", "delay cleared", 32'(in_delay_slot), 32'd0);
    // branch inside a delay slot
    cyc(1, 1, 32'h200, 0, 0, 0, "R3");
    cyc(1, 1, 32'h300, 0, 0, 0, "R3");
    chk("R3", "slot-in-slot pc", pc, 32'h200);
    chk("R3", "slot-in-slot next", pc_next, 32'h300);

    // R5/R6: breakpoint on a delay-slot instruction, consecutive retry
    cyc(1, 0, 0, 0, 0, 1, "R5");
    chk("R5", "halt raised", 32'(halt_o), 32'd1);
    chk("R5", "delay flag kept", 32'(in_delay_slot), 32'd1);
    cyc(1, 0, 0, 0, 0, 1, "R6");
    chk("R6", "retry executes", 32'(exec_o), 32'd1);
    chk("R6", "retry pc", pc, 32'h300);
    cyc(1, 0, 0, 0, 0, 1, "R6");
    chk("R6", "later match halts again", 32'(halt_o), 32'd1);
    // retry after idle cycles
    repeat (3) cyc(0, 0, 0, 0, 0, 1, "R9");
    cyc(1, 0, 0, 0, 0, 1, "R6");
    chk("R6", "retry after stall executes", 32'(exec_o), 32'd1);

    // R8: breakpoint beats exception, then exception on the retry (R7)
    cyc(1, 1, 32'h700, 1, 32'h800, 1, "R8");
    chk("R8", "halt beats exception", 32'(halt_o), 32'd1);
    cyc(1, 1, 32'h700, 1, 32'h800, 1, "R7");
    chk("R7", "no exec on exception", 32'(exec_o), 32'd0);
    chk("R7", "vector in pc_next", pc_next, 32'h800);
    chk("R8", "branch ignored on exception", 32'(in_delay_slot), 32'd0);
    cyc(1, 0, 0, 0, 0, 0, "R7");
    chk("R7", "pc reaches vector", pc, 32'h800);

    // R7: exception while sitting in a delay slot
    cyc(1, 1, 32'h900, 0, 0, 0, "R3");
    cyc(1, 0, 0, 1, 32'hc00, 0, "R7");
    chk("R7", "exception on slot clears flag", 32'(in_delay_slot), 32'd0);
    chk("R7", "pc advanced to target", pc, 32'h900);
    repeat (3) cyc(1, 0, 0, 0, 0, 0, "R2");
    chk("R2", "sequential after vector", pc, 32'hc08);

    // mid-run reset returns to R1 state
    rst = 1'b1;
    cyc(1, 0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0, 0, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule